// File: doc/BRIEF.md
# Predicated SIMD byte write-enable generator

This block sits between a 64-bit SIMD arithmetic unit and the write port of a register file that has one write enable per byte. It takes the arithmetic result, a lane predicate, the element width in use and a mode flag. From these it produces the data to be written and the per-byte write strobes, so that predication needs no read-modify-write of the destination.

The lane predicate has one bit per element. In merge mode, a lane whose predicate bit is clear has all of its byte strobes cleared, and the destination keeps its old bytes. In zeroing mode, every byte strobe is raised and the bytes of masked-out lanes are driven as zero.

The block is purely combinational. A write-valid input gates every strobe, so an idle cycle writes nothing.

Top module: `predwe_gen`

## Requirements
- R1: The width code `ew_i` selects the element width: 0 is 8-bit (8 lanes), 1 is 16-bit (4 lanes), 2 is 32-bit (2 lanes) and 3 is 64-bit (1 lane). Byte j of the datapath belongs to lane j >> `ew_i`.
- R2: In merge mode (`zero_mode_i` = 0) with `wr_valid_i` = 1, strobe bit j equals the predicate bit of the lane that owns byte j. The strobes of every byte in one lane are therefore equal.
- R3: In merge mode, `wdata_o` equals `result_i` unchanged, whatever the predicate.
- R4: In zeroing mode (`zero_mode_i` = 1) with `wr_valid_i` = 1, all 8 strobe bits are 1.
- R5: In zeroing mode, each byte of `wdata_o` is 0x00 when its lane's predicate bit is 0, and equals the matching byte of `result_i` when that bit is 1.
- R6: Predicate bits at or above the active lane count have no effect on either output.
- R7: When `wr_valid_i` = 0, every strobe bit is 0, in both modes.
- R8: The outputs follow any change of the inputs with no clock edge in between.
- R9: With 8-bit elements in merge mode and `wr_valid_i` = 1, `bstrb_o` equals `pred_i` for every predicate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_valid_i | input | 1 | Write request this cycle; gates all strobes |
| zero_mode_i | input | 1 | 1 selects zeroing mode, 0 selects merge mode |
| ew_i | input | 2 | Element width code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| pred_i | input | 8 | Lane predicate, bit i for lane i |
| result_i | input | 64 | Result from the arithmetic unit |
| wdata_o | output | 64 | Data to the register file write port |
| bstrb_o | output | 8 | Byte write enables, bit j for bits 8j+7..8j |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath of eight 8-bit bytes. Under these defaults each of the four width codes gives a lane count that can be reached directly. The 8-bit mode can be swept over all 256 predicate values, and at every narrower lane count the predicate carries ignored upper bits that the bench can set. Table vectors pair each width with both modes and with write-valid high and low. Directed tests then cover the idle state, the exhaustive byte-mode sweep and changes of the inputs with no clock edge between them.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  localparam int EW_W = 2;

  typedef enum logic [EW_W-1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_width_e;

  localparam int NUM_EW = 4;
endpackage

// File: rtl/pwe_lane_map.sv
// Expands a lane predicate into one select bit per byte for the chosen width.
module pwe_lane_map
  import pwe_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES-1:0] pred_i,
  input  elem_width_e       ew_i,
  output logic [NBYTES-1:0] byte_sel_o
);
  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    logic [NUM_EW-1:0] cand;
    for (genvar k = 0; k < NUM_EW; k++) begin : g_w
      // byte j is owned by lane j >> k at width code k
      assign cand[k] = pred_i[j >> k];
    end
    always_comb begin
      unique case (ew_i)
        EW_8:    byte_sel_o[j] = cand[0];
        EW_16:   byte_sel_o[j] = cand[1];
        EW_32:   byte_sel_o[j] = cand[2];
        default: byte_sel_o[j] = cand[3];
      endcase
    end
  end
endmodule

// File: rtl/pwe_data_mask.sv
// Zeroing mode clears bytes of masked lanes; merge mode passes the data.
module pwe_data_mask #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int DW = NBYTES * BYTE_W
) (
  input  logic              zero_mode_i,
  input  logic [NBYTES-1:0] byte_sel_i,
  input  logic [DW-1:0]     result_i,
  output logic [DW-1:0]     wdata_o
);
  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    logic keep;
    assign keep = ~zero_mode_i | byte_sel_i[j];
    assign wdata_o[j*BYTE_W +: BYTE_W] = keep ? result_i[j*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/pwe_strobe.sv
// Byte strobes: all bytes in zeroing mode, selected bytes in merge mode.
module pwe_strobe #(
  parameter int NBYTES = 8
) (
  input  logic              wr_valid_i,
  input  logic              zero_mode_i,
  input  logic [NBYTES-1:0] byte_sel_i,
  output logic [NBYTES-1:0] bstrb_o
);
  logic [NBYTES-1:0] raw;
  assign raw     = zero_mode_i ? {NBYTES{1'b1}} : byte_sel_i;
  assign bstrb_o = wr_valid_i ? raw : '0;
endmodule

// File: rtl/predwe_gen.sv
module predwe_gen
  import pwe_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int DW = NBYTES * BYTE_W
) (
  input  logic              wr_valid_i,
  input  logic              zero_mode_i,
  input  logic [EW_W-1:0]   ew_i,
  input  logic [NBYTES-1:0] pred_i,
  input  logic [DW-1:0]     result_i,
  output logic [DW-1:0]     wdata_o,
  output logic [NBYTES-1:0] bstrb_o
);
  elem_width_e       ew;
  logic [NBYTES-1:0] byte_sel;

  assign ew = elem_width_e'(ew_i);

  pwe_lane_map #(.NBYTES(NBYTES)) u_map (
    .pred_i     (pred_i),
    .ew_i       (ew),
    .byte_sel_o (byte_sel)
  );

  pwe_data_mask #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_data (
    .zero_mode_i (zero_mode_i),
    .byte_sel_i  (byte_sel),
    .result_i    (result_i),
    .wdata_o     (wdata_o)
  );

  pwe_strobe #(.NBYTES(NBYTES)) u_strb (
    .wr_valid_i  (wr_valid_i),
    .zero_mode_i (zero_mode_i),
    .byte_sel_i  (byte_sel),
    .bstrb_o     (bstrb_o)
  );
endmodule

// File: rtl/pwe_check.sv
module pwe_check #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int DW = NBYTES * BYTE_W
) (
  input logic              wr_valid_i,
  input logic              zero_mode_i,
  input logic [1:0]        ew_i,
  input logic [NBYTES-1:0] pred_i,
  input logic [DW-1:0]     result_i,
  input logic [DW-1:0]     wdata_o,
  input logic [NBYTES-1:0] bstrb_o
);
  always_comb begin
    if (!wr_valid_i) begin
      a_r7_idle_no_strobe: assert (bstrb_o == '0);
    end
    if (wr_valid_i && zero_mode_i) begin
      a_r4_zero_full_strobe: assert (&bstrb_o);
    end
    if (!zero_mode_i) begin
      a_r3_merge_data_pass: assert (wdata_o == result_i);
    end
    if (zero_mode_i) begin
      a_r5_zero_no_new_bits: assert ((wdata_o & ~result_i) == '0);
    end
    if (wr_valid_i && !zero_mode_i && ew_i == 2'd0) begin
      a_r9_byte_mode_strobe: assert (bstrb_o == pred_i);
    end
    if (wr_valid_i && !zero_mode_i) begin
      for (int j = 0; j < NBYTES; j++) begin
        a_r2_lane_uniform: assert (bstrb_o[j] == bstrb_o[(j >> ew_i) << ew_i]);
      end
    end
  end
endmodule

bind predwe_gen pwe_check #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_pwe_check (
  .wr_valid_i  (wr_valid_i),
  .zero_mode_i (zero_mode_i),
  .ew_i        (ew_i),
  .pred_i      (pred_i),
  .result_i    (result_i),
  .wdata_o     (wdata_o),
  .bstrb_o     (bstrb_o)
);

// File: tb/predwe_gen_tb_top.sv
module predwe_gen_tb_top;
  localparam int NBYTES = 8;
  localparam int DW = 64;
  localparam logic [63:0] RES = 64'h8877_6655_4433_2211;
  // {valid, zero, ew, pred, result, exp_strb, exp_data}
  localparam int VW = 148;
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 8'hA5, RES, 8'hA5, RES},                    // R2 R3
    {1'b1, 1'b1, 2'd0, 8'hA5, RES, 8'hFF, 64'h8800_6600_0033_0011}, // R4 R5
    {1'b1, 1'b0, 2'd1, 8'h05, RES, 8'h33, RES},                    // R1 R2
    {1'b1, 1'b1, 2'd1, 8'hF2, RES, 8'hFF, 64'h0000_0000_4433_0000}, // R5 R6
    {1'b1, 1'b0, 2'd2, 8'hFE, RES, 8'hF0, RES},                    // R1 R6
    {1'b1, 1'b1, 2'd2, 8'h01, RES, 8'hFF, 64'h0000_0000_4433_2211}, // R5
    {1'b1, 1'b0, 2'd3, 8'hFE, RES, 8'h00, RES},                    // R6
    {1'b1, 1'b1, 2'd3, 8'h01, RES, 8'hFF, RES},                    // R4
    {1'b1, 1'b1, 2'd3, 8'h00, RES, 8'hFF, 64'h0},                  // R5
    {1'b0, 1'b0, 2'd0, 8'hFF, RES, 8'h00, RES},                    // R7
    {1'b0, 1'b1, 2'd1, 8'h03, RES, 8'h00, 64'h0000_0000_4433_2211}, // R7
    {1'b1, 1'b0, 2'd0, 8'h00, RES, 8'h00, RES}                     // R2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              wr_valid_i, zero_mode_i;
  logic [1:0]        ew_i;
  logic [NBYTES-1:0] pred_i;
  logic [DW-1:0]     result_i, wdata_o;
  logic [NBYTES-1:0] bstrb_o;

  predwe_gen dut_i (
    .wr_valid_i (wr_valid_i), .zero_mode_i (zero_mode_i), .ew_i (ew_i),
    .pred_i (pred_i), .result_i (result_i), .wdata_o (wdata_o), .bstrb_o (bstrb_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic z, input logic [1:0] e,
                       input logic [7:0] p, input logic [63:0] r);
    @(negedge clk);
    wr_valid_i = v; zero_mode_i = z; ew_i = e; pred_i = p; result_i = r;
    #2;
  endtask

  initial begin
    wr_valid_i = 1'b0; zero_mode_i = 1'b0; ew_i = 2'd0; pred_i = '0; result_i = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state after reset
    drive(1'b0, 1'b0, 2'd0, 8'h00, 64'h0);
    check("R7 idle strobe", {56'h0, bstrb_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][147], VEC[i][146], VEC[i][145:144], VEC[i][143:136], VEC[i][135:72]);
      check($sformatf("R1/R2/R4/R7 vec%0d strobe", i), {56'h0, bstrb_o}, {56'h0, VEC[i][71:64]});
      check($sformatf("R3/R5/R6 vec%0d data", i), wdata_o, VEC[i][63:0]);
    end

    // R9: exhaustive byte-mode sweep
    for (int p = 0; p < 256; p++) begin
      drive(1'b1, 1'b0, 2'd0, 8'(p), RES);
      check("R9 byte strobe", {56'h0, bstrb_o}, {56'h0, 8'(p)});
    end

    // R6: every upper-bit pattern is ignored at 16-bit width
    for (int u = 0; u < 16; u++) begin
      drive(1'b1, 1'b1, 2'd1, {4'(u), 4'b1001}, RES);
      check("R6 upper bits data", wdata_o, 64'h8877_0000_0000_2211);
    end

    // R8: outputs follow inputs with no clock edge between
    @(negedge clk);
    wr_valid_i = 1'b1; zero_mode_i = 1'b0; ew_i = 2'd2; pred_i = 8'h01; result_i = RES;
    #1;
    check("R8 first value", {56'h0, bstrb_o}, 64'h0F);
    pred_i = 8'h02;
    #1;
    check("R8 same cycle update", {56'h0, bstrb_o}, 64'hF0);
    zero_mode_i = 1'b1;
    #1;
    check("R8 mode update data", wdata_o, 64'h8877_6655_0000_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule